// File: doc/BRIEF.md
# Multi-Rail Power-Good Supervisor

This block watches several supply rails through one comparator bit per rail. A high bit means the rail is above its trip level. Each comparator bit arrives asynchronously. It first passes through a synchronizer chain, then into a per-rail qualifier.

The qualifier's behaviour is asymmetric:
- **Rising:** a rail must stay good without a break for a long validation window before its status goes high.
- **Falling:** once a rail is qualified, a bad level is only reported when it lasts for a short glitch-reject window. Shorter dips are absorbed.

An aggregate power-good output is high only while every rail status is high. It drops in the same cycle that any rail status drops. The other rails keep their own status.

A synchronous, active-high enable switches the whole function off. While it is low, all outputs are low and every qualifier is cleared. When it returns high, every rail validates again from zero. A rail position that is not populated is tied permanently good. It then qualifies on its own and never holds power-good down. Both windows are given in clock cycles as parameters.

Top module: `pgs_supervisor`

## Requirements
- R1: While reset (active-low `rst_n`) is asserted, every bit of `rail_status` and `power_good` is 0.
- R2: A rail's status rises only after its comparator bit has been seen good for RISE_CYC consecutive cycles. Counting the two synchronizer stages, status goes high exactly RISE_CYC+2 clock edges after the input goes high, and not one edge earlier.
- R3: A bad sample of any length during validation discards the progress made so far. The status then rises exactly RISE_CYC+2 edges after the input becomes good again.
- R4: On a qualified rail, a bad pulse lasting fewer than FALL_CYC cycles leaves that rail's status and `power_good` high throughout.
- R5: On a qualified rail, a bad level lasting FALL_CYC cycles or more drops that rail's status exactly FALL_CYC+2 edges after the input goes low.
- R6: When one rail drops, every other rail whose input stays good keeps its status high.
- R7: `power_good` is 1 exactly when all N_CH bits of `rail_status` are 1, in the same cycle.
- R8: While `enable` is 0, `rail_status` and `power_good` are 0 in that same cycle, whatever the rail inputs do.
- R9: When `enable` rises with all rails already good, status rises exactly RISE_CYC edges later. If `enable` falls and rises again part-way, validation restarts from zero.
- R10: A rail tied permanently good from reset qualifies RISE_CYC+2 edges after reset is released. It then never blocks `power_good`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Synchronous monitor enable, active high |
| rail_ok | input | N_CH | Asynchronous comparator bits, 1 = rail above threshold |
| rail_status | output | N_CH | Per-rail qualified status |
| power_good | output | 1 | AND of all rail statuses |

## Verification
The falling path is swept on every rail with dips of every length from one cycle to two past the glitch window. Each of these runs is checked on every cycle. This separates absorbed glitches from real drops, confirms the exact drop edge, and shows that untouched rails keep their status.

The rising path is tested by breaking validation after each possible count of good samples. This shows that no partial progress survives a break, including a break one sample short of the window.

The enable tests cover three cases:
- dropping enable on qualified rails;
- toggling rails while enable is low;
- a short enable pulse followed by a re-enable, which shows that the restart is counted from the last rising edge of enable.

A rail tied good through reset shows that an unused channel qualifies alone and does not hold power-good down.

// File: rtl/pgs_pkg.sv
package pgs_pkg;

  typedef enum logic {
    PH_QUALIFY = 1'b0,
    PH_HOLD    = 1'b1
  } qual_phase_e;

  // Counter bits needed to count 0 .. max(a,b)-1.
  function automatic int unsigned run_width(input int unsigned a, input int unsigned b);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m < 2) ? 1 : $clog2(m);
  endfunction

endpackage

// File: rtl/pgs_sync.sv
module pgs_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/pgs_qualifier.sv
module pgs_qualifier
  import pgs_pkg::*;
#(
  parameter int unsigned RISE_CYC = 16,
  parameter int unsigned FALL_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic good,
  output logic held
);

  localparam int unsigned     CW        = run_width(RISE_CYC, FALL_CYC);
  localparam logic [CW-1:0]   RISE_LAST = CW'(RISE_CYC - 1);
  localparam logic [CW-1:0]   FALL_LAST = CW'(FALL_CYC - 1);

  qual_phase_e   phase_q;
  logic [CW-1:0] run_q;

  // Named events: qualification completes / a real drop is confirmed.
  logic rise_evt, fall_evt, run_clear;

  assign rise_evt  = en && (phase_q == PH_QUALIFY) && good  && (run_q == RISE_LAST);
  assign fall_evt  = en && (phase_q == PH_HOLD)    && !good && (run_q == FALL_LAST);
  // Run is cleared when the input agrees with the current phase.
  assign run_clear = (phase_q == PH_QUALIFY) ? !good : good;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_QUALIFY;
      run_q   <= '0;
    end else if (!en) begin
      phase_q <= PH_QUALIFY;
      run_q   <= '0;
    end else if (rise_evt) begin
      phase_q <= PH_HOLD;
      run_q   <= '0;
    end else if (fall_evt) begin
      phase_q <= PH_QUALIFY;
      run_q   <= '0;
    end else if (run_clear) begin
      run_q   <= '0;
    end else begin
      run_q   <= run_q + 1'b1;
    end
  end

  assign held = (phase_q == PH_HOLD);

endmodule

// File: rtl/pgs_supervisor.sv
module pgs_supervisor #(
  parameter int unsigned N_CH        = 4,
  parameter int unsigned RISE_CYC    = 32_000_000,
  parameter int unsigned FALL_CYC    = 6_000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable,
  input  logic [N_CH-1:0] rail_ok,
  output logic [N_CH-1:0] rail_status,
  output logic            power_good
);

  logic [N_CH-1:0] ok_sync;
  logic [N_CH-1:0] chan_held;

  pgs_sync #(
    .WIDTH (N_CH),
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_in(rail_ok),
    .sync_out(ok_sync)
  );

  generate
    for (genvar g = 0; g < N_CH; g++) begin : g_ch
      pgs_qualifier #(
        .RISE_CYC(RISE_CYC),
        .FALL_CYC(FALL_CYC)
      ) u_qual (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (enable),
        .good (ok_sync[g]),
        .held (chan_held[g])
      );
    end
  endgenerate

  assign rail_status = chan_held & {N_CH{enable}};
  assign power_good  = &rail_status;

endmodule

// File: rtl/pgs_supervisor_chk.sv
module pgs_supervisor_chk #(
  parameter int unsigned N_CH     = 4,
  parameter int unsigned RISE_CYC = 16,
  parameter int unsigned FALL_CYC = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            en,
  input logic [N_CH-1:0] sync_ok,
  input logic [N_CH-1:0] held,
  input logic [N_CH-1:0] rail_status,
  input logic            power_good
);

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (rail_status == '0 && !power_good) else $error("reset outputs"); // R1
    end
  end

  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (held == '0) && (rail_status == '0)); // R8

  AST_PGOOD_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    power_good |-> ($countones(held) == N_CH) && en); // R7

  generate
    for (genvar i = 0; i < N_CH; i++) begin : g_chk
      logic [31:0] good_run, bad_run;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          good_run <= '0;
          bad_run  <= '0;
        end else begin
          good_run <= (en && sync_ok[i]) ? ((good_run == 32'hFFFF_FFFF) ? good_run : good_run + 1) : '0;
          bad_run  <= (!sync_ok[i])      ? ((bad_run  == 32'hFFFF_FFFF) ? bad_run  : bad_run  + 1) : '0;
        end
      end

      AST_RISE_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(held[i]) |-> good_run >= RISE_CYC); // R2

      AST_FALL_FILTERED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(held[i]) && $past(en) |-> bad_run >= FALL_CYC); // R5

      AST_GOOD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        held[i] && en && sync_ok[i] |=> held[i]); // R6
    end
  endgenerate

endmodule

bind pgs_supervisor pgs_supervisor_chk #(
  .N_CH    (N_CH),
  .RISE_CYC(RISE_CYC),
  .FALL_CYC(FALL_CYC)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .en         (enable),
  .sync_ok    (ok_sync),
  .held       (chan_held),
  .rail_status(rail_status),
  .power_good (power_good)
);

// File: tb/pgs_supervisor_test.sv
`timescale 1ns/1ps
module pgs_supervisor_test;

  localparam int unsigned N     = 4;
  localparam int unsigned RISE  = 16;
  localparam int unsigned FALL  = 4;
  localparam logic [N-1:0] ALL  = '1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         enable = 1'b1;
  logic [N-1:0] rail_ok = '0;
  logic [N-1:0] rail_status;
  logic         power_good;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  pgs_supervisor #(
    .N_CH(N), .RISE_CYC(RISE), .FALL_CYC(FALL), .SYNC_STAGES(2)
  ) uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .rail_ok(rail_ok),
    .rail_status(rail_status), .power_good(power_good)
  );

  task automatic report();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // Compare {power_good, rail_status} with expectation; pg computed as AND.
  task automatic chk_out(input string req, input logic [N-1:0] exp_st);
    logic [N:0] act, exp;
    act = {power_good, rail_status};
    exp = {(exp_st == ALL), exp_st};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s t=%0t actual=%0h expected=%0h", req, $time, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    // R1: reset state, with rail 3 tied good throughout
    rail_ok = 4'b1000;
    step(3);
    chk_out("R1 reset", '0);
    rst_n = 1'b1;

    // R10: tied-good rail qualifies alone after reset release
    for (int u = 1; u <= RISE + 2; u++) begin
      step(1);
      chk_out("R10 tied rail", (u == RISE + 2) ? 4'b1000 : 4'b0000);
    end

    // R2 / R7: remaining rails raised; exact qualification edge
    rail_ok = ALL;
    for (int u = 1; u <= RISE + 2; u++) begin
      step(1);
      chk_out("R2 R7 qualify", (u == RISE + 2) ? ALL : 4'b1000);
    end

    // R4 / R5 / R6 / R7: dip length sweep on every rail
    for (int ch = 0; ch < N; ch++) begin
      for (int len = 1; len <= FALL + 2; len++) begin
        logic [N-1:0] dropped;
        dropped = ALL & ~(N'(1) << ch);
        rail_ok[ch] = 1'b0;
        for (int t = 1; t <= FALL + 3; t++) begin
          step(1);
          if (len >= FALL && t >= FALL + 2)
            chk_out("R5 R6 drop", dropped);
          else
            chk_out("R4 glitch", ALL);
          if (t == len) rail_ok[ch] = 1'b1;
        end
        if (len >= FALL) begin
          for (int u = FALL + 3 - len + 1; u <= RISE + 2; u++) begin
            step(1);
            chk_out("R2 requalify", (u == RISE + 2) ? ALL : dropped);
          end
        end
      end
    end

    // R3: break validation after every possible number of good samples
    for (int b = 1; b < RISE; b++) begin
      rail_ok[1] = 1'b0;
      step(FALL + 4);
      chk_out("R3 setup", ALL & ~4'b0010);
      rail_ok[1] = 1'b1;
      step(b);
      rail_ok[1] = 1'b0;
      step(1);
      rail_ok[1] = 1'b1;
      for (int u = 1; u <= RISE + 2; u++) begin
        step(1);
        chk_out("R3 restart", (u == RISE + 2) ? ALL : (ALL & ~4'b0010));
      end
    end

    // R8: enable low forces outputs low at once, rails ignored
    enable = 1'b0;
    #1;
    chk_out("R8 disable same cycle", '0);
    rail_ok = '0;
    step(2);
    chk_out("R8 rails low", '0);
    rail_ok = ALL;
    step(4);
    chk_out("R8 rails good", '0);

    // R9: full revalidation after enable rises
    enable = 1'b1;
    for (int u = 1; u <= RISE; u++) begin
      step(1);
      chk_out("R9 enable rise", (u == RISE) ? ALL : '0);
    end

    // R9: partial enable pulse then restart
    enable = 1'b0;
    #1;
    chk_out("R8 disable again", '0);
    step(2);
    enable = 1'b1;
    step(RISE / 2);
    chk_out("R9 partial", '0);
    enable = 1'b0;
    step(1);
    enable = 1'b1;
    for (int u = 1; u <= RISE; u++) begin
      step(1);
      chk_out("R9 restart", (u == RISE) ? ALL : '0);
    end

    report();
  end

endmodule